// File: doc/BRIEF.md
# Write-Leveling Responder (memory-device side)

This block is a cycle-based digital model of how a DDR memory device behaves during write leveling. It watches the command pins for mode register writes to the second mode register, MR1. It keeps the leveling-enable bit, the output-buffer-disable bit and the nominal termination code from that register. From these it derives the strobe and data termination enables, and it checks the command stream and the termination setting for illegal use.

While leveling is active, every rising edge of the digitized strobe `dqs` captures the digitized clock level `ck_lvl`. After a programmable number of cycles the captured level appears on every data bit. Each bit can carry a small extra delay, which models the mismatch between data bits. Each bit has a valid flag. The flag is clear on entry to the mode and is set by that bit's first feedback, so a controller model can tell undefined data from real feedback.

Top module: `wlvl_responder`

## Requirements
- R1: A mode register write is `cs_n`, `ras_n`, `cas_n` and `we_n` all low. When such a write has `ba` = 3'b001 (MR1), `addr[7]` = 1 sets `wl_active` and `addr[7]` = 0 clears it. The change is visible after the clock edge that samples the command.
- R2: A mode register write to any other bank value leaves `wl_active`, `qoff` and the termination code unchanged.
- R3: While `wl_active` is 1, `dqs_term_en` equals `odt` and `dq_term_en` is 0 for either level of `odt`.
- R4: While `wl_active` is 0, both `dqs_term_en` and `dq_term_en` equal `odt`.
- R5: Every MR1 write loads `qoff` from `addr[12]`. `dq_oe` is 1 only when `wl_active` is 1 and `qoff` is 0.
- R6: Every MR1 write loads the termination code {`addr[9]`,`addr[6]`,`addr[2]`}. `rtt_err` is 1 exactly when `wl_active` is 1, `qoff` is 0 and the code is outside {3'b001, 3'b010, 3'b011}. With `qoff` at 1, every code is accepted.
- R7: While leveling, a selected command (`cs_n` = 0) raises `cmd_err` for one cycle after the edge that samples it. This applies to any command other than a NOP ({`ras_n`,`cas_n`,`we_n`} = 3'b111) or an MR1 write with `addr[7]` = 0. A deselect (`cs_n` = 1) never raises `cmd_err`, and nothing raises it while leveling is off.
- R8: A rising strobe edge is seen at a clock edge E where `dqs` is 1 and `dqs` was 0 at the edge before. It captures `ck_lvl` at E. Bit j of `dq_out` shows that level from edge E + WLO + (j mod (WLOE+1)) onward, and `dq_valid[j]` is set at the same edge.
- R9: On entering leveling, all `dq_valid` bits are 0 and stay 0 until each bit's first feedback.
- R10: Strobe edges while leveling is off are ignored. Leaving the mode clears `dq_out`, `dq_valid` and any feedback still in flight, so `dq_valid` stays 0 outside the mode.
- R11: After reset, `wl_active`, `qoff`, `dq_oe`, `dq_out`, `dq_valid`, `rtt_err` and `cmd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write enable command pin, active low |
| ba | input | 3 | Bank address, selects the mode register |
| addr | input | ADDR_W | Address bus carrying mode register contents |
| odt | input | 1 | Termination control input |
| dqs | input | 1 | Digitized strobe level |
| ck_lvl | input | 1 | Digitized clock level to be sampled |
| wl_active | output | 1 | Leveling mode is on |
| qoff | output | 1 | Output buffer disabled |
| dqs_term_en | output | 1 | Strobe termination enable |
| dq_term_en | output | 1 | Data termination enable |
| dq_oe | output | 1 | Feedback is being driven on the data bits |
| dq_out | output | DQ_W | Feedback level per data bit |
| dq_valid | output | DQ_W | Per-bit feedback valid flag |
| rtt_err | output | 1 | Illegal termination code for the current mode |
| cmd_err | output | 1 | Illegal command seen during leveling |

## Verification
The strobe capture and the command check can fall in the same cycle: a rising `dqs` edge can arrive together with an illegal command, or with an MR1 write that keeps leveling on but changes `qoff` or the termination code. The bench provokes this in its random loop by placing a random command in the very cycle of each strobe rise. It then checks three things on the following edges. `cmd_err` must match the bench's legality rule. The new `qoff` and `rtt_err` values must follow the register written. The captured level must still reach every data bit at its own latency.

// File: rtl/wlvl_responder.sv
module wlvl_responder #(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 14,
  parameter int WLO    = 3,
  parameter int WLOE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [2:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              odt,
  input  logic              dqs,
  input  logic              ck_lvl,
  output logic              wl_active,
  output logic              qoff,
  output logic              dqs_term_en,
  output logic              dq_term_en,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_valid,
  output logic              rtt_err,
  output logic              cmd_err
);
  localparam int DEPTH = WLO + WLOE;

  logic       dqs_q;
  logic [2:0] rtt;
  logic [DEPTH-1:0] p_stb, p_val;

  wire is_mrs   = !cs_n && !ras_n && !cas_n && !we_n;
  wire is_nop   = !cs_n && ras_n && cas_n && we_n;
  wire mr1_wr   = is_mrs && (ba == 3'b001);
  wire exit_cmd = mr1_wr && !addr[7];
  wire flush    = mr1_wr && (addr[7] != wl_active);
  wire rise     = wl_active && dqs && !dqs_q;

  assign dqs_term_en = odt;
  assign dq_term_en  = odt && !wl_active;
  assign dq_oe       = wl_active && !qoff;
  assign rtt_err     = wl_active && !qoff && !(rtt inside {3'd1, 3'd2, 3'd3});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wl_active <= 1'b0;
      qoff      <= 1'b0;
      rtt       <= 3'd0;
      dqs_q     <= 1'b0;
      cmd_err   <= 1'b0;
      p_stb     <= '0;
      p_val     <= '0;
    end else begin
      dqs_q   <= dqs;
      cmd_err <= wl_active && !cs_n && !is_nop && !exit_cmd;
      if (mr1_wr) begin
        wl_active <= addr[7];
        qoff      <= addr[12];
        rtt       <= {addr[9], addr[6], addr[2]};
      end
      if (flush) begin
        p_stb <= '0;
        p_val <= '0;
      end else begin
        p_stb[0] <= rise;
        p_val[0] <= ck_lvl;
        for (int k = 1; k < DEPTH; k++) begin
          p_stb[k] <= p_stb[k-1];
          p_val[k] <= p_val[k-1];
        end
      end
    end
  end

  for (genvar j = 0; j < DQ_W; j++) begin : g_bit
    localparam int LAT = WLO + (j % (WLOE + 1));
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        dq_out[j]   <= 1'b0;
        dq_valid[j] <= 1'b0;
      end else if (p_stb[LAT-1]) begin
        dq_out[j]   <= p_val[LAT-1];
        dq_valid[j] <= 1'b1;
      end
    end
  end

  // R1
  enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_wr && addr[7]) |=> wl_active);
  // R1
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_cmd |=> !wl_active);
  // R5
  qoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_wr && addr[12]) |=> !dq_oe);
  // R7
  nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nop || cs_n) |=> !cmd_err);
  // R9
  fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_active) |-> (dq_valid == '0));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wl_active |-> (dq_valid == '0));
endmodule

// File: tb/wlvl_responder_tb.sv
module wlvl_responder_tb;
  localparam int DQ_W = 8, ADDR_W = 14, WLO = 3, WLOE = 2;
  localparam int DEPTH = WLO + WLOE;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0] ba = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic odt = 0, dqs = 0, ck_lvl = 0;
  logic wl_active, qoff, dqs_term_en, dq_term_en, dq_oe, rtt_err, cmd_err;
  logic [DQ_W-1:0] dq_out, dq_valid;

  int total = 0, bad = 0;
  bit m_wl = 0, m_qoff = 0;
  logic [2:0] m_rtt = 0;
  logic [DQ_W-1:0] e_q = 0, e_v = 0;

  always #5 clk = ~clk;

  wlvl_responder #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .WLO(WLO), .WLOE(WLOE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .odt(odt), .dqs(dqs), .ck_lvl(ck_lvl),
    .wl_active(wl_active), .qoff(qoff), .dqs_term_en(dqs_term_en), .dq_term_en(dq_term_en),
    .dq_oe(dq_oe), .dq_out(dq_out), .dq_valid(dq_valid), .rtt_err(rtt_err), .cmd_err(cmd_err));

  function automatic int lat(int j);
    return WLO + (j % (WLOE + 1));
  endfunction

  function automatic bit exp_rtt_err();
    return m_wl && !m_qoff && !(m_rtt inside {3'd1, 3'd2, 3'd3});
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
  endtask

  task automatic set_mr(input logic [2:0] b, input logic [ADDR_W-1:0] a);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = a;
    if (b == 3'b001) begin
      if (a[7] != m_wl) begin e_q = 0; e_v = 0; end
      m_wl = a[7]; m_qoff = a[12]; m_rtt = {a[9], a[6], a[2]};
    end
  endtask

  function automatic logic [ADDR_W-1:0] mr1(bit wl, bit qo, logic [2:0] code);
    logic [ADDR_W-1:0] a = 0;
    a[7] = wl; a[12] = qo; a[9] = code[2]; a[6] = code[1]; a[2] = code[0];
    return a;
  endfunction

  task automatic chk_mode(string req);
    chk(wl_active == m_wl, req, wl_active, m_wl);
    chk(dq_oe == (m_wl && !m_qoff), req, dq_oe, m_wl && !m_qoff);
    chk(rtt_err == exp_rtt_err(), req, rtt_err, exp_rtt_err());
  endtask

  // strobe rise with whatever command the caller placed on the pins; e_cmd = expected cmd_err
  task automatic pulse(bit lvl, bit e_cmd);
    dqs = 1; ck_lvl = lvl;
    tick();
    chk(cmd_err == e_cmd, "R7", cmd_err, e_cmd);
    chk_mode("R6");
    idle();
    dqs = 0; ck_lvl = ~lvl;
    for (int k = 1; k <= DEPTH; k++) begin
      tick();
      for (int j = 0; j < DQ_W; j++)
        if (m_wl && k >= lat(j)) begin e_q[j] = lvl; e_v[j] = 1; end
      chk(dq_out == e_q, "R8", dq_out, e_q);
      chk(dq_valid == e_v, "R8", dq_valid, e_v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit e_cmd;
    r = $urandom(32'd2024);
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    chk({wl_active, qoff, dq_oe, rtt_err, cmd_err} == 0, "R11", {wl_active, qoff, dq_oe, rtt_err, cmd_err}, 0);
    chk(dq_out == 0 && dq_valid == 0, "R11", {dq_out, dq_valid}, 0);
    // R4
    odt = 1; #1;
    chk(dqs_term_en && dq_term_en, "R4", {dqs_term_en, dq_term_en}, 2'b11);
    odt = 0; #1;
    chk(!dqs_term_en && !dq_term_en, "R4", {dqs_term_en, dq_term_en}, 2'b00);
    // R10 strobe ignored outside mode
    pulse(1'b1, 1'b0);
    chk(dq_valid == 0, "R10", dq_valid, 0);
    // R2 other bank
    set_mr(3'b010, mr1(1, 1, 3'd1)); tick(); idle();
    chk(!wl_active && !qoff, "R2", {wl_active, qoff}, 0);
    // R7 illegal command outside mode not flagged
    cs_n = 0; ras_n = 0; tick(); idle();
    chk(!cmd_err, "R7", cmd_err, 0);
    // R1 enter, R9 valid clear
    set_mr(3'b001, mr1(1, 0, 3'd1)); tick(); idle();
    chk_mode("R1");
    chk(dq_valid == 0, "R9", dq_valid, 0);
    // R3
    odt = 1; #1;
    chk(dqs_term_en && !dq_term_en, "R3", {dqs_term_en, dq_term_en}, 2'b10);
    odt = 0; #1;
    chk(!dqs_term_en && !dq_term_en, "R3", {dqs_term_en, dq_term_en}, 2'b00);
    // R8 directed: two levels
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
    // random: command in the same cycle as each strobe rise
    for (int i = 0; i < 60; i++) begin
      r = $urandom();
      cs_n = r[0] & r[1]; ras_n = r[2]; cas_n = r[3]; we_n = r[4]; ba = r[7:5];
      addr = r[8 +: ADDR_W];
      if (!cs_n && !ras_n && !cas_n && !we_n && ba == 3'b001) begin
        addr[7] = 1;
        m_qoff = addr[12]; m_rtt = {addr[9], addr[6], addr[2]};
      end
      e_cmd = !cs_n && !(ras_n && cas_n && we_n);
      pulse(r[30], e_cmd);
    end
    // R6 corner codes
    set_mr(3'b001, mr1(1, 0, 3'd4)); tick(); idle();
    chk(rtt_err, "R6", rtt_err, 1);
    set_mr(3'b001, mr1(1, 0, 3'd3)); tick(); idle();
    chk(!rtt_err, "R6", rtt_err, 0);
    set_mr(3'b001, mr1(1, 1, 3'd0)); tick(); idle();
    chk(!rtt_err, "R6", rtt_err, 0);
    chk(!dq_oe && qoff, "R5", {dq_oe, qoff}, 2'b01);
    // R1 exit, legal MRS so no cmd_err; R10 clears
    set_mr(3'b001, mr1(0, 0, 3'd4)); tick(); idle();
    chk_mode("R1");
    chk(!cmd_err, "R7", cmd_err, 0);
    chk(dq_valid == 0 && dq_out == 0, "R10", {dq_out, dq_valid}, 0);
    // R9 re-entry, valid clear
    set_mr(3'b001, mr1(1, 0, 3'd2)); tick(); idle();
    chk(dq_valid == 0, "R9", dq_valid, 0);
    pulse(1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule